// File: doc/BRIEF.md
# Warp Counting Barrier Unit

This block holds a small set of hardware barriers that warps of one core use to wait for each other. Each arrival names a barrier, the number of participants that barrier needs, and the warp that is arriving. The block keeps one bit per warp for each barrier and sets the arriving warp's bit.

When an arrival brings the number of distinct recorded warps up to the required count or past it, the block releases the barrier. On the next cycle it raises a one-cycle activation vector with a bit set for every recorded warp, and it empties the barrier so the barrier can be used again. The required count travels with every arrival; nothing is configured ahead of time.

The upstream decode logic presents at most one arrival per cycle. The warp state logic downstream treats the activation vector as a set of wake-up strobes.

Top module: `barrier_unit`

## Requirements
- R1: After a synchronous active-low reset, `wake_mask` is all zero and every barrier is empty, so warps recorded before the reset do not count afterwards.
- R2: An accepted arrival records its warp in the named barrier. Bit i of the barrier's record stands for warp id i.
- R3: An accepted arrival releases its barrier when the number of distinct recorded warps, the arriving warp included, is greater than or equal to `arr_count`. In the cycle after the arrival, `wake_mask` has exactly the recorded warps set. Bit i stands for warp id i.
- R4: A release leaves the barrier empty, so the next use of that barrier counts from zero.
- R5: An accepted arrival that leaves the distinct count below `arr_count` produces an all-zero `wake_mask` in the following cycle.
- R6: An arrival by a warp that is already recorded in the barrier does not raise that barrier's count.
- R7: `wake_mask` is non-zero only in the cycle directly after an arrival, so each activation lasts a single cycle.
- R8: An arrival is ignored if its barrier id is NUM_BARRIERS or above, or if its warp id is NUM_WARPS or above. No barrier changes and `wake_mask` stays zero.
- R9: Barriers are independent. Arrivals on one barrier neither count toward nor clear another.
- R10: A count of 0 or 1 releases the arriving warp at once. A count above NUM_WARPS never releases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| arr_valid | input | 1 | An arrival is presented this cycle |
| arr_bar_id | input | BAR_W | Barrier the arrival targets |
| arr_count | input | CNT_W | Number of distinct warps needed for release |
| arr_warp | input | WARP_W | Id of the arriving warp |
| wake_mask | output | NUM_WARPS | One-cycle activation vector, one bit per warp |

## Verification
Two functions can land on the same cycle. One is a release pulse on `wake_mask` from the previous arrival. The other is a new arrival to the same barrier, which must count from an empty record. The bench provokes this case with back-to-back arrivals that have no idle cycle between them. It judges the outcome by the expected mask of the next release, which must hold only the warps that arrived after the emptying. A second collision is an interleaved stream across all barriers with mixed in-range and out-of-range ids. Each cycle's pulse is compared with a per-barrier bitmask model kept in the bench.

// File: rtl/barrier_pkg.sv
// Package: shared helpers for the warp barrier unit.
// Assumes: callers pass a positive element count.
package barrier_pkg;

    // Index width for n elements, never below one bit.
    function automatic int idx_w(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/barrier_decode.sv
// Module: barrier_decode
// Turns one arrival into a per-barrier select and a one-hot warp vector.
// Assumes: ids at or above the configured counts mark the arrival invalid.
module barrier_decode #(
    parameter int NUM_BARRIERS = 3,
    parameter int NUM_WARPS    = 6,
    localparam int BAR_W  = barrier_pkg::idx_w(NUM_BARRIERS),
    localparam int WARP_W = barrier_pkg::idx_w(NUM_WARPS)
) (
    input  logic                    arr_valid,
    input  logic [BAR_W-1:0]        arr_bar_id,
    input  logic [WARP_W-1:0]       arr_warp,
    output logic [NUM_BARRIERS-1:0] bar_hit,
    output logic [NUM_WARPS-1:0]    warp_oh
);
    localparam logic [BAR_W:0]  BAR_LIM  = (BAR_W+1)'(NUM_BARRIERS);
    localparam logic [WARP_W:0] WARP_LIM = (WARP_W+1)'(NUM_WARPS);

    logic accept;

    // Qualify the arrival: both ids must be in range.
    always_comb begin
        accept = arr_valid
               && ({1'b0, arr_bar_id} < BAR_LIM)
               && ({1'b0, arr_warp} < WARP_LIM);
    end

    // Build the one-hot vector of the arriving warp.
    always_comb begin
        warp_oh = '0;
        if (accept) begin
            warp_oh[arr_warp] = 1'b1;
        end
    end

    // One select line per barrier.
    for (genvar b = 0; b < NUM_BARRIERS; b++) begin : g_sel
        localparam logic [BAR_W-1:0] MY_ID = BAR_W'(b);
        assign bar_hit[b] = accept && (arr_bar_id == MY_ID);
    end
endmodule

// File: rtl/barrier_slot.sv
// Module: barrier_slot
// One barrier: holds the set of arrived warps, counts it, releases it.
// Assumes: warp_oh is one-hot or zero; hit is asserted for at most one slot.
module barrier_slot #(
    parameter int NUM_WARPS = 6,
    localparam int CNT_W = barrier_pkg::idx_w(NUM_WARPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic [NUM_WARPS-1:0] warp_oh,
    input  logic [CNT_W-1:0]     need_cnt,
    output logic [NUM_WARPS-1:0] held,
    output logic [NUM_WARPS-1:0] fire_mask
);
    logic [NUM_WARPS-1:0] merged;
    logic [CNT_W-1:0]     tally;
    logic                 release_now;

    // Set that would be held after this arrival, and its size.
    always_comb begin
        merged = held | (hit ? warp_oh : '0);
        tally  = '0;
        for (int i = 0; i < NUM_WARPS; i++) begin
            tally = tally + CNT_W'(merged[i]);
        end
        release_now = hit && (tally >= need_cnt);
        fire_mask   = release_now ? merged : '0;
    end

    // Record arrivals; empty the set on release or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (release_now) begin
            held <= '0;
        end else if (hit) begin
            held <= merged;
        end
    end
endmodule

// File: rtl/barrier_wake_merge.sv
// Module: barrier_wake_merge
// Combines the release masks of all barriers into one registered pulse.
// Assumes: at most one barrier releases per cycle.
module barrier_wake_merge #(
    parameter int NUM_BARRIERS = 3,
    parameter int NUM_WARPS    = 6
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_BARRIERS-1:0][NUM_WARPS-1:0] fire,
    output logic [NUM_WARPS-1:0]                   wake_mask
);
    logic [NUM_WARPS-1:0] any_fire;

    // OR together every barrier's release mask.
    always_comb begin
        any_fire = '0;
        for (int b = 0; b < NUM_BARRIERS; b++) begin
            any_fire = any_fire | fire[b];
        end
    end

    // Register the merged mask as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_mask <= '0;
        end else begin
            wake_mask <= any_fire;
        end
    end
endmodule

// File: rtl/barrier_unit.sv
// Module: barrier_unit (top)
// Counting barriers for the warps of one core. Arrivals are recorded per
// barrier; a barrier whose distinct-warp count meets the supplied count
// releases its warps on wake_mask one cycle later and is emptied.
// Assumes: at most one arrival per cycle; out-of-range ids are dropped.
module barrier_unit #(
    parameter int NUM_BARRIERS = 3,
    parameter int NUM_WARPS    = 6,
    localparam int BAR_W  = barrier_pkg::idx_w(NUM_BARRIERS),
    localparam int WARP_W = barrier_pkg::idx_w(NUM_WARPS),
    localparam int CNT_W  = barrier_pkg::idx_w(NUM_WARPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arr_valid,
    input  logic [BAR_W-1:0]     arr_bar_id,
    input  logic [CNT_W-1:0]     arr_count,
    input  logic [WARP_W-1:0]    arr_warp,
    output logic [NUM_WARPS-1:0] wake_mask
);
    logic [NUM_BARRIERS-1:0]                bar_hit;
    logic [NUM_WARPS-1:0]                   warp_oh;
    logic [NUM_BARRIERS-1:0][NUM_WARPS-1:0] slot_held;
    logic [NUM_BARRIERS-1:0][NUM_WARPS-1:0] slot_fire;

    barrier_decode #(
        .NUM_BARRIERS (NUM_BARRIERS),
        .NUM_WARPS    (NUM_WARPS)
    ) u_decode (
        .arr_valid  (arr_valid),
        .arr_bar_id (arr_bar_id),
        .arr_warp   (arr_warp),
        .bar_hit    (bar_hit),
        .warp_oh    (warp_oh)
    );

    for (genvar b = 0; b < NUM_BARRIERS; b++) begin : g_slot
        barrier_slot #(
            .NUM_WARPS (NUM_WARPS)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       (bar_hit[b]),
            .warp_oh   (warp_oh),
            .need_cnt  (arr_count),
            .held      (slot_held[b]),
            .fire_mask (slot_fire[b])
        );
    end

    barrier_wake_merge #(
        .NUM_BARRIERS (NUM_BARRIERS),
        .NUM_WARPS    (NUM_WARPS)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (slot_fire),
        .wake_mask (wake_mask)
    );
endmodule

// File: rtl/barrier_unit_chk.sv
// Module: barrier_unit_chk
// Temporal checks on the barrier unit, attached by bind.
// Assumes: the held input is the per-barrier record of the top.
module barrier_unit_chk #(
    parameter int NUM_BARRIERS = 3,
    parameter int NUM_WARPS    = 6,
    localparam int BAR_W  = barrier_pkg::idx_w(NUM_BARRIERS),
    localparam int WARP_W = barrier_pkg::idx_w(NUM_WARPS),
    localparam int CNT_W  = barrier_pkg::idx_w(NUM_WARPS + 1)
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   arr_valid,
    input logic [BAR_W-1:0]                       arr_bar_id,
    input logic [CNT_W-1:0]                       arr_count,
    input logic [WARP_W-1:0]                      arr_warp,
    input logic [NUM_WARPS-1:0]                   wake_mask,
    input logic [NUM_BARRIERS-1:0][NUM_WARPS-1:0] held
);
    localparam logic [BAR_W:0]  BAR_LIM  = (BAR_W+1)'(NUM_BARRIERS);
    localparam logic [WARP_W:0] WARP_LIM = (WARP_W+1)'(NUM_WARPS);

    logic                 bar_bad;
    logic [NUM_WARPS-1:0] cur_oh;
    logic [NUM_WARPS-1:0] prev_oh;
    logic [CNT_W-1:0]     prev_cnt;
    logic [BAR_W-1:0]     prev_bar;

    // Classify the present arrival independently of the design.
    always_comb begin
        bar_bad = ({1'b0, arr_bar_id} >= BAR_LIM);
        cur_oh  = '0;
        if ({1'b0, arr_warp} < WARP_LIM) begin
            cur_oh[arr_warp] = 1'b1;
        end
    end

    // Remember the previous cycle's arrival fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_oh  <= '0;
            prev_cnt <= '0;
            prev_bar <= '0;
        end else begin
            prev_oh  <= cur_oh;
            prev_cnt <= arr_count;
            prev_bar <= arr_bar_id;
        end
    end

    AST_WAKE_NEEDS_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_valid |=> (wake_mask == '0)); // R7

    AST_WAKE_HAS_ARRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        arr_valid |=> ((wake_mask == '0) || ((wake_mask & prev_oh) != '0))); // R3

    AST_WAKE_MEETS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_mask != '0) |-> ($countones(wake_mask) >= int'(prev_cnt))); // R3

    AST_EMPTY_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_mask != '0) |-> (held[prev_bar] == '0)); // R4

    AST_BAD_BAR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && bar_bad) |=> ((wake_mask == '0) && $stable(held))); // R8
endmodule

bind barrier_unit barrier_unit_chk #(
    .NUM_BARRIERS (NUM_BARRIERS),
    .NUM_WARPS    (NUM_WARPS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arr_valid  (arr_valid),
    .arr_bar_id (arr_bar_id),
    .arr_count  (arr_count),
    .arr_warp   (arr_warp),
    .wake_mask  (wake_mask),
    .held       (slot_held)
);

// File: tb/barrier_unit_bench.sv
// Bench: sweeps every barrier, every count and two warp orders, then an
// interleaved stream and back-to-back reuse, against a bitmask model.
module barrier_unit_bench;
    localparam int NB    = 3;
    localparam int NW    = 6;
    localparam int BAR_W  = barrier_pkg::idx_w(NB);
    localparam int WARP_W = barrier_pkg::idx_w(NW);
    localparam int CNT_W  = barrier_pkg::idx_w(NW + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              arr_valid = 1'b0;
    logic [BAR_W-1:0]  arr_bar_id = '0;
    logic [CNT_W-1:0]  arr_count = '0;
    logic [WARP_W-1:0] arr_warp = '0;
    logic [NW-1:0]     wake_mask;

    int checks = 0;
    int errors = 0;
    logic [NW-1:0] mdl [NB];

    always #5 clk = ~clk;

    barrier_unit #(.NUM_BARRIERS(NB), .NUM_WARPS(NW)) u_barrier_unit (
        .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_bar_id(arr_bar_id),
        .arr_count(arr_count), .arr_warp(arr_warp), .wake_mask(wake_mask)
    );

    task automatic check(input string req, input logic [NW-1:0] act, input logic [NW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: wake_mask=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int b = 0; b < NB; b++) mdl[b] = '0;
    endtask

    // Present one arrival; check the pulse one cycle later.
    task automatic arrive(input int b, input int c, input int w, input bit wait_first);
        logic [NW-1:0] nxt;
        logic [NW-1:0] exp;
        string tag;
        if (wait_first) @(negedge clk);
        arr_valid  = 1'b1;
        arr_bar_id = BAR_W'(b);
        arr_count  = CNT_W'(c);
        arr_warp   = WARP_W'(w);
        exp = '0;
        if (b >= NB || w >= NW) begin
            tag = "R8";
        end else begin
            nxt = mdl[b];
            nxt[w] = 1'b1;
            if ($countones(nxt) >= c) begin
                exp = nxt;
                mdl[b] = '0;
                tag = (c <= 1) ? "R10" : "R3";
            end else begin
                tag = mdl[b][w] ? "R6" : ((c > NW) ? "R10" : "R5");
                mdl[b] = nxt;
            end
        end
        @(negedge clk);
        arr_valid = 1'b0;
        check(tag, wake_mask, exp);
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R7", wake_mask, '0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        check("R1", wake_mask, '0);
        rst_n = 1'b1;

        // R1: partial record is forgotten across reset.
        arrive(0, 6, 0, 1);
        arrive(0, 6, 1, 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", wake_mask, '0);
        rst_n = 1'b1;
        clear_model();
        arrive(0, 2, 2, 1);
        arrive(0, 2, 3, 1);

        // R2 R3 R5 R6 R10: every barrier, count and two arrival orders.
        for (int b = 0; b < NB; b++) begin
            for (int c = 0; c < 8; c++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int k = 0; k < 8; k++) begin
                        arrive(b, c, (k * (s == 0 ? 1 : 5)) % NW, 1);
                    end
                    idle_check();
                end
            end
        end

        // R9 R8: interleaved barriers with out-of-range ids mixed in.
        for (int k = 0; k < 96; k++) begin
            arrive(k % 4, (k * 3) % 8, (k * 7) % 8, 1);
        end

        // R4: back-to-back release and reuse on the same barrier.
        clear_model();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        arrive(1, 2, 0, 1);
        arrive(1, 2, 1, 0);
        arrive(1, 2, 1, 0);
        arrive(1, 2, 4, 0);
        arrive(2, 1, 5, 0);
        arrive(1, 3, 3, 0);
        arrive(1, 3, 2, 0);
        idle_check();

        finish_run();
    end
endmodule